// File: doc/BRIEF.md
# Victim Buffer Cache

This block pairs a direct-mapped L1 data cache with a small, fully associative victim buffer. It serves one processor access at a time: a read returns one word, a write merges one word into the line it addresses. On each accepted access the L1 set and every victim buffer entry are compared in the same cycle. An L1 hit completes at once. If L1 misses and the buffer hits, the wanted line and the line in its L1 set trade places, with no memory traffic. If both miss, the line is fetched from memory. The L1 line it replaces is pushed into the buffer, and the buffer line pushed out to make room goes back to memory only if it holds modified data.

Addresses are byte addresses. Bits [3:2] select the word inside a 16-byte line, bits [7:4] select one of the 16 L1 sets, and the bits above them are the L1 tag. The victim buffer keeps the whole line address (byte address bits [31:4]) for each of its 4 entries, together with a valid flag, a dirty flag and the line data. The memory port is a read request with a fixed-length line reply, plus a one-cycle write pulse that needs no acknowledgement.

Top module: `victim_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid, mem_rd_req and mem_wr_valid are 0, and the first access to any line is a miss that requests memory.
- R2: An access that hits in L1 raises resp_valid on the first clock edge after the edge that accepts it, and causes no memory read or write.
- R3: An access that misses in L1 and hits in the victim buffer raises resp_valid on the second edge after acceptance and issues no memory read.
- R4: After a buffer hit, the requested line sits in L1, so the next access to it responds in one cycle. The line that was displaced from L1 sits in the buffer, so the next access to it responds in two cycles.
- R5: An access that misses in both issues one mem_rd_req pulse with mem_rd_addr equal to the access address with bits [3:0] cleared. resp_valid follows on the edge that samples mem_rd_valid.
- R6: Each valid L1 line displaced by a memory fill enters the buffer. The lowest-numbered empty entry is used first; when none is empty, the least recently used entry is replaced. A swap counts as a use of the entry involved.
- R7: When the replaced buffer entry is dirty, mem_wr_valid pulses in the same cycle as resp_valid, carrying that line's address (bits [3:0] zero) and its current data. A clean replaced entry is dropped without any write.
- R8: Moving a dirty line out of L1 never writes memory; only eviction from the victim buffer does.
- R9: A write stores req_wdata in the word at bits [3:2] and marks the line dirty, and the dirty mark travels with the line through swaps. A read returns the most recent value written to that word, or the memory value if the word was never written.
- R10: req_ready is 0 from the edge that accepts a buffer hit or a miss until its response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write a word, 0 = read a word |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Word to write |
| resp_valid | output | 1 | Access complete, one-cycle pulse |
| resp_rdata | output | 32 | Word read (or the word written) |
| mem_rd_req | output | 1 | Line read request, one-cycle pulse |
| mem_rd_addr | output | 32 | Line address of the read |
| mem_rd_valid | input | 1 | Read line present on mem_rd_data |
| mem_rd_data | input | 128 | Read line data, word 0 in the low bits |
| mem_wr_valid | output | 1 | Line write-back, one-cycle pulse |
| mem_wr_addr | output | 32 | Line address of the write-back |
| mem_wr_data | output | 128 | Line data of the write-back |

## Verification
The refill of L1 from memory and the write-back of a dirty buffer victim happen in the same cycle. The bench provokes this by cycling six or more tags through one set, with writes mixed in, so that the full buffer is forced to give up lines, some dirty and some clean. A reference model with timestamped recency predicts whether a write-back is due and which line it must carry. Each write-back is judged by its address and by every word of its data, compared against the values the bench itself wrote. A long mixed sweep adds swaps that fall between these events, so that recency and dirty marks have to survive swaps.

// File: rtl/vc_pkg.sv
package vc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SWAP = 2'd1,
        ST_WAIT = 2'd2
    } vc_state_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int N     = 4,
    parameter int KEY_W = 28,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              valid,
    input  logic [N-1:0][KEY_W-1:0]   keys,
    input  logic [KEY_W-1:0]          probe,
    output logic                      hit,
    output logic [IW-1:0]             hit_idx
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (keys[g] == probe);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |hit_vec;

    // A line address is held by at most one buffer entry (R6)
    assert_single_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] oldest
);
    logic [N-1:0][IW-1:0] age_d, age_q;
    logic [N-1:0]         old_mask;

    always_comb begin
        age_d = age_q;
        if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
            end
            age_d[touch_idx] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
        end else begin
            age_q <= age_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_old
        assign old_mask[g] = (age_q[g] == IW'(N - 1));
    end

    always_comb begin
        oldest = '0;
        for (int i = 0; i < N; i++) begin
            if (old_mask[i]) oldest = IW'(i);
        end
    end

    // Ages stay a permutation: exactly one least recent entry (R6)
    assert_one_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(old_mask) == 1);

    // A touched entry becomes the most recent one (R6)
    assert_touch_recent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (age_q[$past(touch_idx)] == '0));
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 16,
    parameter int VB_N       = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [WORD_W-1:0]            req_wdata,
    output logic                         resp_valid,
    output logic [WORD_W-1:0]            resp_rdata,
    output logic                         mem_rd_req,
    output logic [ADDR_W-1:0]            mem_rd_addr,
    input  logic                         mem_rd_valid,
    input  logic [LINE_WORDS*WORD_W-1:0] mem_rd_data,
    output logic                         mem_wr_valid,
    output logic [ADDR_W-1:0]            mem_wr_addr,
    output logic [LINE_WORDS*WORD_W-1:0] mem_wr_data
);
    import vc_pkg::*;

    localparam int LINE_W = LINE_WORDS * WORD_W;
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int TAG_W  = LA_W - IDX_W;
    localparam int VI_W   = (VB_N > 1) ? $clog2(VB_N) : 1;

    typedef struct packed {
        vc_state_e                       st;
        logic                            wr;
        logic [LA_W-1:0]                 la;
        logic [WSEL_W-1:0]               ws;
        logic [WORD_W-1:0]               wd;
        logic [VI_W-1:0]                 vidx;
        logic [SETS-1:0]                 l1_v;
        logic [SETS-1:0]                 l1_dt;
        logic [SETS-1:0][TAG_W-1:0]      l1_tag;
        logic [SETS-1:0][LINE_W-1:0]     l1_data;
        logic [VB_N-1:0]                 vb_v;
        logic [VB_N-1:0]                 vb_dt;
        logic [VB_N-1:0][LA_W-1:0]       vb_la;
        logic [VB_N-1:0][LINE_W-1:0]     vb_data;
        logic                            resp_v;
        logic [WORD_W-1:0]               resp_w;
        logic                            rd_req;
        logic [ADDR_W-1:0]               rd_addr;
        logic                            wb_v;
        logic [ADDR_W-1:0]               wb_addr;
        logic [LINE_W-1:0]               wb_data;
    } regs_t;

    regs_t d, q;

    function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] sel,
                                                   input logic [WORD_W-1:0] w);
        logic [LINE_W-1:0] r;
        r = line;
        r[sel*WORD_W +: WORD_W] = w;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] sel);
        return line[sel*WORD_W +: WORD_W];
    endfunction

    // Lookup key: live request while idle, latched access otherwise
    logic [LA_W-1:0]  cur_la;
    logic [IDX_W-1:0] cur_set;
    logic [TAG_W-1:0] cur_tag;
    logic             l1_hit;
    logic             vb_hit;
    logic [VI_W-1:0]  vb_idx;
    logic             lru_touch;
    logic [VI_W-1:0]  lru_idx;
    logic [VI_W-1:0]  lru_oldest;
    logic [VI_W-1:0]  ins_slot;

    assign cur_la  = (q.st == ST_IDLE) ? req_addr[ADDR_W-1:OFF_W] : q.la;
    assign cur_set = cur_la[IDX_W-1:0];
    assign cur_tag = cur_la[LA_W-1:IDX_W];
    assign l1_hit  = q.l1_v[cur_set] && (q.l1_tag[cur_set] == cur_tag);

    vc_match #(.N(VB_N), .KEY_W(LA_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (q.vb_v),
        .keys    (q.vb_la),
        .probe   (cur_la),
        .hit     (vb_hit),
        .hit_idx (vb_idx)
    );

    vc_lru #(.N(VB_N)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (lru_touch),
        .touch_idx (lru_idx),
        .oldest    (lru_oldest)
    );

    // Empty entries are filled first, lowest index wins
    always_comb begin
        logic found;
        ins_slot = lru_oldest;
        found    = 1'b0;
        for (int i = 0; i < VB_N; i++) begin
            if (!q.vb_v[i] && !found) begin
                ins_slot = VI_W'(i);
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        logic [LINE_W-1:0] line;
        d         = q;
        d.resp_v  = 1'b0;
        d.rd_req  = 1'b0;
        d.wb_v    = 1'b0;
        lru_touch = 1'b0;
        lru_idx   = '0;
        line      = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr = req_write;
                    d.la = cur_la;
                    d.ws = req_addr[OFF_W-1:BYTE_W];
                    d.wd = req_wdata;
                    if (l1_hit) begin
                        d.resp_v = 1'b1;
                        if (req_write) begin
                            d.l1_data[cur_set] = put_word(q.l1_data[cur_set],
                                                          req_addr[OFF_W-1:BYTE_W], req_wdata);
                            d.l1_dt[cur_set]   = 1'b1;
                            d.resp_w           = req_wdata;
                        end else begin
                            d.resp_w = get_word(q.l1_data[cur_set], req_addr[OFF_W-1:BYTE_W]);
                        end
                    end else if (vb_hit) begin
                        d.st   = ST_SWAP;
                        d.vidx = vb_idx;
                    end else begin
                        d.st      = ST_WAIT;
                        d.rd_req  = 1'b1;
                        d.rd_addr = {cur_la, {OFF_W{1'b0}}};
                    end
                end
            end
            ST_SWAP: begin
                line = q.vb_data[q.vidx];
                if (q.wr) line = put_word(line, q.ws, q.wd);
                d.resp_w  = q.wr ? q.wd : get_word(line, q.ws);
                d.resp_v  = 1'b1;
                d.l1_data[cur_set] = line;
                d.l1_tag[cur_set]  = cur_tag;
                d.l1_v[cur_set]    = 1'b1;
                d.l1_dt[cur_set]   = q.vb_dt[q.vidx] | q.wr;
                d.vb_v[q.vidx]     = q.l1_v[cur_set];
                d.vb_dt[q.vidx]    = q.l1_dt[cur_set];
                d.vb_la[q.vidx]    = {q.l1_tag[cur_set], cur_set};
                d.vb_data[q.vidx]  = q.l1_data[cur_set];
                lru_touch = 1'b1;
                lru_idx   = q.vidx;
                d.st      = ST_IDLE;
            end
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    line = mem_rd_data;
                    if (q.wr) line = put_word(line, q.ws, q.wd);
                    d.resp_w = q.wr ? q.wd : get_word(line, q.ws);
                    d.resp_v = 1'b1;
                    if (q.l1_v[cur_set]) begin
                        if (q.vb_v[ins_slot] && q.vb_dt[ins_slot]) begin
                            d.wb_v    = 1'b1;
                            d.wb_addr = {q.vb_la[ins_slot], {OFF_W{1'b0}}};
                            d.wb_data = q.vb_data[ins_slot];
                        end
                        d.vb_v[ins_slot]    = 1'b1;
                        d.vb_dt[ins_slot]   = q.l1_dt[cur_set];
                        d.vb_la[ins_slot]   = {q.l1_tag[cur_set], cur_set};
                        d.vb_data[ins_slot] = q.l1_data[cur_set];
                        lru_touch = 1'b1;
                        lru_idx   = ins_slot;
                    end
                    d.l1_data[cur_set] = line;
                    d.l1_tag[cur_set]  = cur_tag;
                    d.l1_v[cur_set]    = 1'b1;
                    d.l1_dt[cur_set]   = q.wr;
                    d.st               = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready    = (q.st == ST_IDLE);
    assign resp_valid   = q.resp_v;
    assign resp_rdata   = q.resp_w;
    assign mem_rd_req   = q.rd_req;
    assign mem_rd_addr  = q.rd_addr;
    assign mem_wr_valid = q.wb_v;
    assign mem_wr_addr  = q.wb_addr;
    assign mem_wr_data  = q.wb_data;

    // L1 hit answers on the next edge without memory traffic (R2)
    assert_l1_hit_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && l1_hit) |=> (resp_valid && !mem_rd_req && !mem_wr_valid));

    // Buffer hit: no read request, answer two edges after acceptance (R3)
    assert_swap_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !l1_hit && vb_hit) |=> (!resp_valid && !mem_rd_req) ##1 resp_valid);

    // A read request only follows a double miss in the idle state (R5)
    assert_rd_after_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> $past(req_ready && req_valid && !l1_hit && !vb_hit));

    // Write-backs only come with a memory fill (R7)
    assert_wb_with_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (resp_valid && $past(q.st == ST_WAIT && mem_rd_valid)));

    // A swap never writes memory (R8)
    assert_swap_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SWAP) |=> !mem_wr_valid);

    // Not ready while a slow access is in flight (R10)
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !l1_hit) |=> !req_ready);
endmodule

// File: tb/tb_victim_cache.sv
module tb_victim_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_rd_req;
    logic [31:0]  mem_rd_addr;
    logic         mem_rd_valid = 1'b0;
    logic [127:0] mem_rd_data = '0;
    logic         mem_wr_valid;
    logic [31:0]  mem_wr_addr;
    logic [127:0] mem_wr_data;

    always #5 clk = ~clk;

    victim_cache dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference memory and processor-visible values
    logic [31:0]  truth  [int];
    logic [127:0] wb_mem [int];
    int           wb_cnt = 0;
    int           wb_last_la = -1;

    // Reference cache state
    bit l1v [16]; int l1a [16]; bit l1d [16];
    bit vv [4];   int va [4];   bit vd [4]; int vst [4];
    int tick = 0;

    function automatic logic [31:0] mem_word(input int wa);
        return (32'(wa) * 32'h0100_0193) ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [31:0] cur_word(input int wa);
        if (truth.exists(wa)) return truth[wa];
        return mem_word(wa);
    endfunction

    function automatic logic [127:0] mem_line(input int la);
        logic [127:0] r;
        if (wb_mem.exists(la)) return wb_mem[la];
        for (int w = 0; w < 4; w++) r[w*32 +: 32] = mem_word(la * 4 + w);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Write-back monitor: data must match what the processor last wrote (R7)
    always @(negedge clk) begin
        if (rst_n && mem_wr_valid) begin
            int la;
            la = int'(mem_wr_addr >> 4);
            wb_cnt++;
            wb_last_la = la;
            for (int w = 0; w < 4; w++)
                check(mem_wr_data[w*32 +: 32] == cur_word(la * 4 + w), "R7", "write-back word",
                      mem_wr_data[w*32 +: 32], cur_word(la * 4 + w));
            check(mem_wr_addr[3:0] == 4'h0, "R7", "write-back offset", mem_wr_addr, {mem_wr_addr[31:4], 4'h0});
            wb_mem[la] = mem_wr_data;
        end
    end

    task automatic do_access(input bit wr, input int la, input int w, input logic [31:0] wd);
        int s, kind, k, v, lat, wb0, exp_wb_la, rd_la, wa;
        bit exp_wb, saw_rd, nd;
        logic [31:0] exp_rd;
        s = la % 16;
        wa = la * 4 + w;
        exp_rd = wr ? wd : cur_word(wa);
        exp_wb = 0; exp_wb_la = -1; saw_rd = 0; rd_la = -1;
        if (l1v[s] && l1a[s] == la) begin
            kind = 0;
            if (wr) l1d[s] = 1;
        end else begin
            k = -1;
            for (int i = 0; i < 4; i++) if (vv[i] && va[i] == la) k = i;
            if (k >= 0) begin
                kind = 1;
                nd = vd[k] | wr;
                vv[k] = l1v[s]; va[k] = l1a[s]; vd[k] = l1d[s]; vst[k] = ++tick;
                l1v[s] = 1; l1a[s] = la; l1d[s] = nd;
            end else begin
                kind = 2;
                if (l1v[s]) begin
                    v = -1;
                    for (int i = 0; i < 4; i++) if (!vv[i] && v < 0) v = i;
                    if (v < 0) begin
                        v = 0;
                        for (int i = 1; i < 4; i++) if (vst[i] < vst[v]) v = i;
                    end
                    if (vv[v] && vd[v]) begin exp_wb = 1; exp_wb_la = va[v]; end
                    vv[v] = 1; va[v] = l1a[s]; vd[v] = l1d[s]; vst[v] = ++tick;
                end
                l1v[s] = 1; l1a[s] = la; l1d[s] = wr;
            end
        end
        wb0 = wb_cnt;

        @(negedge clk);
        req_valid = 1; req_write = wr; req_wdata = wd;
        req_addr  = (32'(la) << 4) | (32'(w) << 2);
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        if (kind != 0) check(!req_ready, "R10", "ready while busy", 32'(req_ready), 0);
        while (!resp_valid && lat < 40) begin
            if (mem_rd_req) begin
                saw_rd = 1;
                rd_la  = int'(mem_rd_addr >> 4);
                check(mem_rd_addr[3:0] == 4'h0, "R5", "read offset", mem_rd_addr, {mem_rd_addr[31:4], 4'h0});
                @(negedge clk); lat++;
                mem_rd_valid = 1; mem_rd_data = mem_line(rd_la);
                @(negedge clk); lat++;
                mem_rd_valid = 0;
            end else begin
                @(negedge clk); lat++;
            end
        end
        #1;
        if (!wr) check(resp_rdata == exp_rd, "R9", "read data", resp_rdata, exp_rd);
        if (wr) truth[wa] = wd;
        if (kind == 0) check(lat == 1 && !saw_rd, "R2", "L1 hit latency", 32'(lat), 1);
        if (kind == 1) check(lat == 2 && !saw_rd, "R3", "buffer hit latency R4", 32'(lat), 2);
        if (kind == 2) check(saw_rd && rd_la == la, "R5", "miss read line", 32'(rd_la), 32'(la));
        check((wb_cnt - wb0) == int'(exp_wb), "R7", "write-back count R8 R6", 32'(wb_cnt - wb0), 32'(exp_wb));
        if (exp_wb) check(wb_last_la == exp_wb_la, "R6", "write-back line", 32'(wb_last_la), 32'(exp_wb_la));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(req_ready == 1, "R1", "ready in reset", 32'(req_ready), 1);
        check(!resp_valid && !mem_rd_req && !mem_wr_valid, "R1", "idle outputs",
              {29'd0, resp_valid, mem_rd_req, mem_wr_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1 && !resp_valid, "R1", "ready after reset", 32'(req_ready), 1);

        // R1 R5: cold misses over every set, then R2 hits
        for (int s = 0; s < 16; s++) do_access(0, s, s % 4, 0);
        for (int s = 0; s < 16; s++) do_access(0, s, (s + 1) % 4, 0);

        // R4: swap back and forth in set 3
        do_access(1, 16 + 3, 2, 32'hDEAD_0003);
        do_access(0, 3, 1, 0);
        do_access(0, 16 + 3, 2, 0);
        do_access(0, 16 + 3, 2, 0);
        do_access(0, 3, 0, 0);

        // R6 R7 R8: overflow the buffer through one set
        for (int r = 0; r < 36; r++)
            do_access(r % 2 == 0, ((r % 6) + 2) * 16 + 5, r % 4, 32'h5000_0000 + 32'(r));

        // R9: mixed sweep with conflicts across four sets
        for (int r = 0; r < 600; r++)
            do_access(r % 3 == 1, ((r * 7) % 6) * 16 + ((r * 3) % 4), r % 4,
                      (32'(r) * 32'h1111) ^ 32'hABCD_0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule